// File: doc/BRIEF.md
# Registered DIMM Control-Word Sequencer

This engine loads the register control words of DDR3 registered DIMMs in one channel. After a start pulse it walks the chip selects two at a time. For every pair with at least one present chip select, it works out each control-word value and issues the word as a write command on the DRAM bank and address lines. It enables the pair's two chip selects while each command is offered.

A downstream command engine takes each command through a send/acknowledge handshake. The sequencer keeps fixed gaps between commands, plus a settling delay at the start and a stabilization delay at the end. All three delays are set in clock cycles by parameters.

A second mode, chosen at start, prepares the buffers for a clock-speed change. In this mode each present pair receives only the speed word (word 10). There are no settling or stabilization delays in this mode. The per-DIMM programmable words arrive on input buses indexed by DIMM number, which is the chip-select pair number.

Top module: `rdimm_cw_seq`

## Requirements
- R1: A command for word number w (4 bits) with value v (4 bits) drives bank_o = {w[3], v[3], v[2]} and addr_o[4:0] = {v[1], v[0], w[2], w[1], w[0]}, with addr_o[ADDR_W-1:5] = 0. While cmd_send_o is low, bank_o, addr_o and cs_en_o are all zero.
- R2: In initialization mode (freq_mode_i = 0), each present pair receives words 0 to 15 in ascending order. Words 6 and 7 are never issued.
- R3: Word 0 carries 4'h2 and word 9 carries 4'hD. Word 1 carries 4'hC when single_rank_i[d] is set for DIMM d, and 4'h0 otherwise.
- R4: Words 2, 3, 4, 5 and 8 carry bits [3:0] of the DIMM's field [d*IN_W +: IN_W] on rc2_i, rc3_i, rc4_i, rc5_i and rc8_i; the upper field bits have no effect. All other words, including word 10 in initialization mode, carry 4'h0.
- R5: Pair p (chip selects 2p and 2p+1) is served only when either of its presence bits is set. Pairs are served in ascending order. During its commands cs_en_o = 2'b11 << 2p.
- R6: At least GAP_CYC cycles with cmd_send_o low come before every command. In initialization mode, the first command rises no earlier than INIT_CYC+GAP_CYC cycles after start. done_o follows the last acknowledge by at least STAB_CYC cycles.
- R7: In frequency-change mode, each present pair receives only word 10, with value 1 for speed_i = 2'd1 (1066), 2 for 2'd2 (1333) and 3 for 2'd3 (1600). For speed_i = 2'd0 no command is issued and the sequence still completes.
- R8: cmd_send_o stays high with stable bank_o, addr_o and cs_en_o until cmd_ack_i is sampled high. It is low in the following cycle.
- R9: busy_o is high from the cycle after an accepted start until the cycle after done_o. done_o is a one-cycle pulse at the end of each sequence. After reset all outputs are zero.
- R10: A start_i that arrives while busy_o is high, including the cycle of done_o, is ignored: it changes neither the commands issued nor the number of done pulses.
- R11: A start with an all-zero presence mask produces done_o in the next cycle and no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| freq_mode_i | input | 1 | 0: full initialization, 1: frequency-change sequence |
| speed_i | input | 2 | Data-rate code for word 10: 1=1066, 2=1333, 3=1600, 0=other |
| cs_present_i | input | NUM_CS | Chip-select presence mask |
| single_rank_i | input | NUM_CS/2 | Single-rank flag per DIMM |
| rc2_i | input | NUM_CS/2*IN_W | Per-DIMM value of word 2 |
| rc3_i | input | NUM_CS/2*IN_W | Per-DIMM value of word 3 |
| rc4_i | input | NUM_CS/2*IN_W | Per-DIMM value of word 4 |
| rc5_i | input | NUM_CS/2*IN_W | Per-DIMM value of word 5 |
| rc8_i | input | NUM_CS/2*IN_W | Per-DIMM value of word 8 |
| cmd_ack_i | input | 1 | Command taken by the command engine |
| cmd_send_o | output | 1 | Command offered |
| bank_o | output | 3 | Bank lines of the command |
| addr_o | output | ADDR_W | Address lines of the command |
| cs_en_o | output | NUM_CS | Chip-select enable mask of the command |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | End-of-sequence pulse |

## Verification
Two events can land in the same cycle: a new start and the done pulse of the sequence that is finishing. The bench raises start_i exactly in the cycle where done_o is seen high. It then expects busy_o to fall, no further command to appear and no second done pulse. A second collision occurs when a start arrives partway through a sequence with the opposite mode selected. That case is judged by comparing the full command list against the list for the first start alone.

// File: rtl/rdimm_cw_pkg.sv
package rdimm_cw_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_INIT, S_PICK, S_GAP, S_SEND, S_STAB, S_DONE
  } seq_state_t;

  localparam logic [3:0] WORD_SPEED = 4'd10;
  localparam logic [3:0] WORD_LAST  = 4'd15;
  localparam logic [3:0] VAL_W0     = 4'h2;
  localparam logic [3:0] VAL_W1_SR  = 4'hC;
  localparam logic [3:0] VAL_W9     = 4'hD;
endpackage

// File: rtl/rdimm_cw_timer.sv
module rdimm_cw_timer #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/rdimm_cw_pair_scan.sv
module rdimm_cw_pair_scan #(
  parameter int NUM_PAIRS = 4,
  parameter int PAIR_W    = 3
) (
  input  logic [2*NUM_PAIRS-1:0] mask_i,
  input  logic [PAIR_W-1:0]      from_i,
  output logic                   found_o,
  output logic [PAIR_W-1:0]      idx_o
);
  logic [NUM_PAIRS-1:0] hit;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_hit
    assign hit[p] = (|mask_i[2*p +: 2]) && (PAIR_W'(p) >= from_i);
  end

  // lowest qualifying pair wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int p = NUM_PAIRS - 1; p >= 0; p--) begin
      if (hit[p]) begin
        found_o = 1'b1;
        idx_o   = PAIR_W'(p);
      end
    end
  end
endmodule

// File: rtl/rdimm_cw_value.sv
module rdimm_cw_value
  import rdimm_cw_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int DIMM_W    = 2,
  parameter int IN_W      = 8
) (
  input  logic [3:0]              word_i,
  input  logic [DIMM_W-1:0]       dimm_i,
  input  logic                    freq_i,
  input  logic [1:0]              speed_i,
  input  logic [NUM_PAIRS-1:0]    single_rank_i,
  input  logic [NUM_PAIRS*IN_W-1:0] rc2_i,
  input  logic [NUM_PAIRS*IN_W-1:0] rc3_i,
  input  logic [NUM_PAIRS*IN_W-1:0] rc4_i,
  input  logic [NUM_PAIRS*IN_W-1:0] rc5_i,
  input  logic [NUM_PAIRS*IN_W-1:0] rc8_i,
  output logic [3:0]              val_o
);
  logic [IN_W-1:0] f2, f3, f4, f5, f8;
  logic            unused_fields;

  assign f2 = rc2_i[dimm_i*IN_W +: IN_W];
  assign f3 = rc3_i[dimm_i*IN_W +: IN_W];
  assign f4 = rc4_i[dimm_i*IN_W +: IN_W];
  assign f5 = rc5_i[dimm_i*IN_W +: IN_W];
  assign f8 = rc8_i[dimm_i*IN_W +: IN_W];
  assign unused_fields = ^{f2, f3, f4, f5, f8};

  always_comb begin
    unique case (word_i)
      4'd0:    val_o = VAL_W0;
      4'd1:    val_o = single_rank_i[dimm_i] ? VAL_W1_SR : 4'h0;
      4'd2:    val_o = f2[3:0];
      4'd3:    val_o = f3[3:0];
      4'd4:    val_o = f4[3:0];
      4'd5:    val_o = f5[3:0];
      4'd8:    val_o = f8[3:0];
      4'd9:    val_o = VAL_W9;
      4'd10:   val_o = freq_i ? {2'b00, speed_i} : 4'h0;
      default: val_o = 4'h0;
    endcase
  end
endmodule

// File: rtl/rdimm_cw_encode.sv
module rdimm_cw_encode #(
  parameter int ADDR_W = 16
) (
  input  logic [3:0]        word_i,
  input  logic [3:0]        val_i,
  output logic [2:0]        bank_o,
  output logic [ADDR_W-1:0] addr_o
);
  // word -> {BA2, A2..A0}, value -> {BA1, BA0, A4, A3}
  always_comb begin
    bank_o      = {word_i[3], val_i[3:2]};
    addr_o      = '0;
    addr_o[2:0] = word_i[2:0];
    addr_o[4:3] = val_i[1:0];
  end
endmodule

// File: rtl/rdimm_cw_seq.sv
module rdimm_cw_seq
  import rdimm_cw_pkg::*;
#(
  parameter int NUM_CS   = 8,
  parameter int ADDR_W   = 16,
  parameter int IN_W     = 8,
  parameter int INIT_CYC = 16,
  parameter int GAP_CYC  = 8,
  parameter int STAB_CYC = 12,
  localparam int NUM_PAIRS = NUM_CS / 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      freq_mode_i,
  input  logic [1:0]                speed_i,
  input  logic [NUM_CS-1:0]         cs_present_i,
  input  logic [NUM_PAIRS-1:0]      single_rank_i,
  input  logic [NUM_PAIRS*IN_W-1:0] rc2_i,
  input  logic [NUM_PAIRS*IN_W-1:0] rc3_i,
  input  logic [NUM_PAIRS*IN_W-1:0] rc4_i,
  input  logic [NUM_PAIRS*IN_W-1:0] rc5_i,
  input  logic [NUM_PAIRS*IN_W-1:0] rc8_i,
  input  logic                      cmd_ack_i,
  output logic                      cmd_send_o,
  output logic [2:0]                bank_o,
  output logic [ADDR_W-1:0]         addr_o,
  output logic [NUM_CS-1:0]         cs_en_o,
  output logic                      busy_o,
  output logic                      done_o
);
  localparam int DIMM_W  = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;
  localparam int PAIR_W  = DIMM_W + 1;
  localparam int MAX_CYC = (INIT_CYC > GAP_CYC) ? ((INIT_CYC > STAB_CYC) ? INIT_CYC : STAB_CYC)
                                                : ((GAP_CYC > STAB_CYC) ? GAP_CYC : STAB_CYC);
  localparam int TMR_W   = $clog2(MAX_CYC + 1);
  localparam logic [TMR_W-1:0] INIT_LD = TMR_W'(INIT_CYC - 1);
  localparam logic [TMR_W-1:0] GAP_LD  = TMR_W'(GAP_CYC - 1);
  localparam logic [TMR_W-1:0] STAB_LD = TMR_W'(STAB_CYC - 1);

  seq_state_t          state_q, state_d;
  logic [PAIR_W-1:0]   pair_q, pair_d;
  logic [3:0]          word_q, word_d;
  logic [NUM_CS-1:0]   mask_q, mask_d;
  logic                freq_q, freq_d;
  logic [1:0]          speed_q, speed_d;
  logic                send_q, send_d;
  logic [2:0]          bank_q, bank_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [NUM_CS-1:0]   cs_q, cs_d;

  logic                tmr_ld, tmr_exp;
  logic [TMR_W-1:0]    tmr_val;
  logic                found;
  logic [PAIR_W-1:0]   found_idx;
  logic [3:0]          cur_val;
  logic [2:0]          enc_bank;
  logic [ADDR_W-1:0]   enc_addr;
  logic                advance, last_word;
  logic [3:0]          next_word;

  rdimm_cw_timer #(.W(TMR_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_ld),
    .val_i    (tmr_val),
    .expired_o(tmr_exp)
  );

  rdimm_cw_pair_scan #(.NUM_PAIRS(NUM_PAIRS), .PAIR_W(PAIR_W)) u_scan (
    .mask_i (mask_q),
    .from_i (pair_q),
    .found_o(found),
    .idx_o  (found_idx)
  );

  rdimm_cw_value #(.NUM_PAIRS(NUM_PAIRS), .DIMM_W(DIMM_W), .IN_W(IN_W)) u_value (
    .word_i       (word_q),
    .dimm_i       (pair_q[DIMM_W-1:0]),
    .freq_i       (freq_q),
    .speed_i      (speed_q),
    .single_rank_i(single_rank_i),
    .rc2_i        (rc2_i),
    .rc3_i        (rc3_i),
    .rc4_i        (rc4_i),
    .rc5_i        (rc5_i),
    .rc8_i        (rc8_i),
    .val_o        (cur_val)
  );

  rdimm_cw_encode #(.ADDR_W(ADDR_W)) u_enc (
    .word_i(word_q),
    .val_i (cur_val),
    .bank_o(enc_bank),
    .addr_o(enc_addr)
  );

  assign last_word = freq_q || (word_q == WORD_LAST);
  assign next_word = (word_q == 4'd5) ? 4'd8 : word_q + 4'd1;  // skip reserved 6, 7

  always_comb begin
    state_d = state_q;
    pair_d  = pair_q;
    word_d  = word_q;
    mask_d  = mask_q;
    freq_d  = freq_q;
    speed_d = speed_q;
    send_d  = send_q;
    bank_d  = bank_q;
    addr_d  = addr_q;
    cs_d    = cs_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    advance = 1'b0;

    unique case (state_q)
      S_IDLE: if (start_i) begin
        mask_d  = cs_present_i;
        freq_d  = freq_mode_i;
        speed_d = speed_i;
        pair_d  = '0;
        if (cs_present_i == '0) state_d = S_DONE;
        else if (freq_mode_i)   state_d = S_PICK;
        else begin
          state_d = S_INIT;
          tmr_ld  = 1'b1;
          tmr_val = INIT_LD;
        end
      end
      S_INIT: if (tmr_exp) state_d = S_PICK;
      S_PICK: begin
        if (found) begin
          pair_d  = found_idx;
          word_d  = freq_q ? WORD_SPEED : 4'd0;
          tmr_ld  = 1'b1;
          tmr_val = GAP_LD;
          state_d = S_GAP;
        end else if (freq_q) begin
          state_d = S_DONE;
        end else begin
          tmr_ld  = 1'b1;
          tmr_val = STAB_LD;
          state_d = S_STAB;
        end
      end
      S_GAP: if (tmr_exp) begin
        if (freq_q && speed_q == 2'd0) begin
          advance = 1'b1;
        end else begin
          send_d  = 1'b1;
          bank_d  = enc_bank;
          addr_d  = enc_addr;
          cs_d    = NUM_CS'(2'b11) << {pair_q, 1'b0};
          state_d = S_SEND;
        end
      end
      S_SEND: if (cmd_ack_i) begin
        send_d  = 1'b0;
        bank_d  = '0;
        addr_d  = '0;
        cs_d    = '0;
        advance = 1'b1;
      end
      S_STAB: if (tmr_exp) state_d = S_DONE;
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase

    if (advance) begin
      if (last_word) begin
        pair_d  = pair_q + 1'b1;
        state_d = S_PICK;
      end else begin
        word_d  = next_word;
        tmr_ld  = 1'b1;
        tmr_val = GAP_LD;
        state_d = S_GAP;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pair_q  <= '0;
      word_q  <= '0;
      mask_q  <= '0;
      freq_q  <= 1'b0;
      speed_q <= '0;
      send_q  <= 1'b0;
      bank_q  <= '0;
      addr_q  <= '0;
      cs_q    <= '0;
    end else begin
      state_q <= state_d;
      pair_q  <= pair_d;
      word_q  <= word_d;
      mask_q  <= mask_d;
      freq_q  <= freq_d;
      speed_q <= speed_d;
      send_q  <= send_d;
      bank_q  <= bank_d;
      addr_q  <= addr_d;
      cs_q    <= cs_d;
    end
  end

  assign cmd_send_o = send_q;
  assign bank_o     = bank_q;
  assign addr_o     = addr_q;
  assign cs_en_o    = cs_q;
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_DONE);
endmodule

// File: rtl/rdimm_cw_seq_chk.sv
module rdimm_cw_seq_chk #(
  parameter int NUM_CS  = 8,
  parameter int ADDR_W  = 16,
  parameter int GAP_CYC = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_ack_i,
  input logic              cmd_send_o,
  input logic [2:0]        bank_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [NUM_CS-1:0] cs_en_o,
  input logic              busy_o,
  input logic              done_o
);
  localparam int GW = $clog2(GAP_CYC + 1);
  logic [GW-1:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        low_cnt <= '0;
    else if (cmd_send_o)                low_cnt <= '0;
    else if (low_cnt != GW'(GAP_CYC))   low_cnt <= low_cnt + 1'b1;
  end

  AST_IDLE_LINES_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_send_o |-> (bank_o == 3'b0 && addr_o == '0 && cs_en_o == '0)); // R1
  AST_ADDR_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_send_o |-> (addr_o[ADDR_W-1:5] == '0)); // R1
  AST_NO_RESERVED_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_send_o |-> !(bank_o[2] == 1'b0 && addr_o[2:1] == 2'b11)); // R2
  AST_CS_PAIR_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_send_o |-> ($countones(cs_en_o) == 2)); // R5
  AST_GAP_BEFORE_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_send_o && !$past(cmd_send_o)) |-> (low_cnt >= GW'(GAP_CYC))); // R6
  AST_SEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_send_o && !cmd_ack_i) |=> (cmd_send_o && $stable(bank_o) && $stable(addr_o) && $stable(cs_en_o))); // R8
  AST_SEND_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_send_o && cmd_ack_i) |=> !cmd_send_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_IDLE_NO_SEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!cmd_send_o && !done_o)); // R9
endmodule

bind rdimm_cw_seq rdimm_cw_seq_chk #(
  .NUM_CS (NUM_CS),
  .ADDR_W (ADDR_W),
  .GAP_CYC(GAP_CYC)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmd_ack_i (cmd_ack_i),
  .cmd_send_o(cmd_send_o),
  .bank_o    (bank_o),
  .addr_o    (addr_o),
  .cs_en_o   (cs_en_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/rdimm_cw_seq_tb_top.sv
module rdimm_cw_seq_tb_top;
  localparam int NUM_CS   = 8;
  localparam int NP       = NUM_CS / 2;
  localparam int ADDR_W   = 16;
  localparam int IN_W     = 8;
  localparam int INIT_CYC = 16;
  localparam int GAP_CYC  = 8;
  localparam int STAB_CYC = 12;
  localparam int MAXC     = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, freq_mode_i = 1'b0, cmd_ack_i = 1'b0;
  logic [1:0] speed_i = '0;
  logic [NUM_CS-1:0] cs_present_i = '0;
  logic [NP-1:0] single_rank_i = '0;
  logic [NP*IN_W-1:0] rc2_i = '0, rc3_i = '0, rc4_i = '0, rc5_i = '0, rc8_i = '0;
  logic cmd_send_o, busy_o, done_o;
  logic [2:0] bank_o;
  logic [ADDR_W-1:0] addr_o;
  logic [NUM_CS-1:0] cs_en_o;

  always #5 clk = ~clk;

  rdimm_cw_seq #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .IN_W(IN_W), .INIT_CYC(INIT_CYC),
                 .GAP_CYC(GAP_CYC), .STAB_CYC(STAB_CYC)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .freq_mode_i(freq_mode_i),
    .speed_i(speed_i), .cs_present_i(cs_present_i), .single_rank_i(single_rank_i),
    .rc2_i(rc2_i), .rc3_i(rc3_i), .rc4_i(rc4_i), .rc5_i(rc5_i), .rc8_i(rc8_i),
    .cmd_ack_i(cmd_ack_i), .cmd_send_o(cmd_send_o), .bank_o(bank_o), .addr_o(addr_o),
    .cs_en_o(cs_en_o), .busy_o(busy_o), .done_o(done_o));

  int tests = 0, fails = 0;
  int got_n = 0;
  logic [2:0]        got_bank [MAXC];
  logic [ADDR_W-1:0] got_addr [MAXC];
  logic [NUM_CS-1:0] got_cs   [MAXC];
  int exp_n;
  logic [2:0]        exp_bank [MAXC];
  logic [ADDR_W-1:0] exp_addr [MAXC];
  logic [NUM_CS-1:0] exp_cs   [MAXC];
  int lat = 0;
  int low_cnt = 0, since_start = 0, since_ack = 0, done_cnt = 0;
  bit first_seen = 0, init_run = 0, gap_bad = 0, init_bad = 0;
  int gap_act = 0, init_act = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // command engine: random acknowledge latency, records each command taken
  initial forever begin
    @(negedge clk);
    if (cmd_ack_i) cmd_ack_i = 1'b0;
    else if (cmd_send_o) begin
      if (lat == 0) begin
        cmd_ack_i = 1'b1;
        if (got_n < MAXC) begin
          got_bank[got_n] = bank_o;
          got_addr[got_n] = addr_o;
          got_cs[got_n]   = cs_en_o;
        end
        got_n++;
        since_ack = 0;
        lat = $urandom_range(0, 3);
      end else lat--;
    end
  end

  // timing monitor for R6
  logic prev_send = 1'b0;
  always @(negedge clk) begin
    if (cmd_send_o && !prev_send) begin
      if (low_cnt < GAP_CYC) begin gap_bad = 1; gap_act = low_cnt; end
      if (!first_seen && init_run && since_start < INIT_CYC + GAP_CYC) begin
        init_bad = 1; init_act = since_start;
      end
      first_seen = 1;
    end
    low_cnt     = cmd_send_o ? 0 : low_cnt + 1;
    since_start = since_start + 1;
    since_ack   = since_ack + 1;
    if (done_o) done_cnt++;
    prev_send = cmd_send_o;
  end

  function automatic logic [3:0] exp_val(int w, int p, bit fm, logic [1:0] spd);
    case (w)
      0: return 4'h2;
      1: return single_rank_i[p] ? 4'hC : 4'h0;
      2: return rc2_i[p*IN_W +: 4];
      3: return rc3_i[p*IN_W +: 4];
      4: return rc4_i[p*IN_W +: 4];
      5: return rc5_i[p*IN_W +: 4];
      8: return rc8_i[p*IN_W +: 4];
      9: return 4'hD;
      10: return fm ? {2'b00, spd} : 4'h0;
      default: return 4'h0;
    endcase
  endfunction

  task automatic add_exp(int w, logic [3:0] v, int p);
    logic [3:0] wb;
    wb = 4'(w);
    exp_bank[exp_n] = {wb[3], v[3:2]};
    exp_addr[exp_n] = {11'b0, v[1:0], wb[2:0]};
    exp_cs[exp_n]   = NUM_CS'(2'b11) << (2 * p);
    exp_n++;
  endtask

  task automatic build_exp(logic [NUM_CS-1:0] m, bit fm, logic [1:0] spd);
    exp_n = 0;
    for (int p = 0; p < NP; p++) begin
      if (|m[2*p +: 2]) begin
        if (fm) begin
          if (spd != 2'd0) add_exp(10, exp_val(10, p, fm, spd), p);
        end else begin
          for (int w = 0; w < 16; w++)
            if (w != 6 && w != 7) add_exp(w, exp_val(w, p, fm, spd), p);
        end
      end
    end
  endtask

  // mode 0: plain, 1: second start mid-run, 2: start in the done cycle
  task automatic run_seq(logic [NUM_CS-1:0] m, bit fm, logic [1:0] spd, int mode, string tag);
    int wait_c;
    build_exp(m, fm, spd);
    @(negedge clk);
    got_n = 0; done_cnt = 0; first_seen = 0; gap_bad = 0; init_bad = 0;
    init_run = !fm; since_start = 0;
    cs_present_i = m; freq_mode_i = fm; speed_i = spd; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1 || m == '0, {tag, " R9 busy after start"}, busy_o, 1);
    if (mode == 1) begin
      repeat (30) @(negedge clk);
      freq_mode_i = !fm; cs_present_i = ~m; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait_c = 0;
    while (!done_o && wait_c < 5000) begin @(negedge clk); wait_c++; end
    check(done_o == 1'b1, {tag, " R9 done reached"}, done_o, 1);
    if (!fm && exp_n > 0)
      check(since_ack >= STAB_CYC, {tag, " R6 stabilization delay"}, since_ack, STAB_CYC);
    if (mode == 2) start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(done_o == 1'b0, {tag, " R9 done is one cycle"}, done_o, 0);
    repeat (40) @(negedge clk);
    check(busy_o == 1'b0, {tag, " R10 idle after sequence"}, busy_o, 0);
    check(done_cnt == 1, {tag, " R10 single done pulse"}, done_cnt, 1);
    check(got_n == exp_n, {tag, " R2/R5/R7 command count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      check(got_bank[i] == exp_bank[i], $sformatf("%s R1/R3/R4 bank cmd %0d", tag, i), got_bank[i], exp_bank[i]);
      check(got_addr[i] == exp_addr[i], $sformatf("%s R1/R3/R4 addr cmd %0d", tag, i), got_addr[i], exp_addr[i]);
      check(got_cs[i] == exp_cs[i], $sformatf("%s R5 cs_en cmd %0d", tag, i), got_cs[i], exp_cs[i]);
    end
    check(!gap_bad, {tag, " R6 inter-command gap"}, gap_act, GAP_CYC);
    check(!init_bad, {tag, " R6 initial settling"}, init_act, INIT_CYC + GAP_CYC);
  endtask

  task automatic rand_values();
    single_rank_i = NP'($urandom);
    rc2_i = {$urandom, $urandom}; rc3_i = {$urandom, $urandom};
    rc4_i = {$urandom, $urandom}; rc5_i = {$urandom, $urandom};
    rc8_i = {$urandom, $urandom};
  endtask

  initial begin
    void'($urandom(32'h5eed_0c3a));
    repeat (3) @(negedge clk);
    // reset state (R9, R1)
    check(busy_o == 0 && done_o == 0 && cmd_send_o == 0, "R9 reset idle", {busy_o, done_o, cmd_send_o}, 0);
    check(bank_o == 0 && addr_o == 0 && cs_en_o == 0, "R1 reset lines zero", addr_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R11: empty mask -> done next cycle, no command
    got_n = 0;
    cs_present_i = '0; freq_mode_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(done_o == 1'b1, "R11 done next cycle", done_o, 1);
    @(negedge clk);
    check(done_o == 1'b0, "R11 done one cycle", done_o, 0);
    check(got_n == 0, "R11 no command", got_n, 0);

    // directed: R3/R4 upper field bits ignored, single vs dual rank
    single_rank_i = 4'b0101;
    rc2_i = 32'hF5A3_C7E1; rc3_i = 32'h1F2E_3D4C; rc4_i = 32'hA0B1_C2D3;
    rc5_i = 32'h9988_7766; rc8_i = 32'hFFF0_0F5A;
    run_seq(8'b0000_0011, 1'b0, 2'd0, 0, "init_pair0");
    run_seq(8'b1000_0100, 1'b0, 2'd0, 0, "init_pairs13");
    // R7 speed codes
    run_seq(8'b0011_0001, 1'b1, 2'd1, 0, "freq1066");
    run_seq(8'b1111_1111, 1'b1, 2'd2, 0, "freq1333");
    run_seq(8'b0100_0000, 1'b1, 2'd3, 0, "freq1600");
    run_seq(8'b1111_1111, 1'b1, 2'd0, 0, "freq_other");
    // R10: start mid-run and start in the done cycle
    run_seq(8'b0000_1010, 1'b0, 2'd0, 1, "mid_start");
    run_seq(8'b0010_0000, 1'b1, 2'd3, 2, "start_at_done");
    run_seq(8'b0000_0001, 1'b0, 2'd0, 2, "init_start_at_done");

    // constrained random
    for (int k = 0; k < 8; k++) begin
      logic [NUM_CS-1:0] m;
      rand_values();
      m = NUM_CS'($urandom);
      run_seq(m, 1'($urandom), 2'($urandom), $urandom_range(0, 2), $sformatf("rand%0d", k));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(10 * 200000);
    tests++; fails++;
    $display("FAIL watchdog R9 actual=0x0 expected=0x1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule